// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two 16-bit unsigned operands and a carry-in with no clock and no stored state. The operands are split into four 4-bit slices. Each slice forms per-bit generate (a AND b) and propagate (a XOR b) terms. It expands every internal carry into a flat AND-OR sum of products of its own carry-in, and it reports a group generate and a group propagate for its four bits.

A second lookahead unit of the same shape takes the four slice-level generate/propagate pairs and the external carry-in. From them it forms, in parallel, the carry into slices 1, 2 and 3 and the final carry-out. No carry passes from one slice directly to the next. The second-level unit also exports its own group generate and group propagate, so a parent lookahead unit can combine four of these adders into a wider one. The slice width is set in the shared package, and the operand width follows from it as the square of that width.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in`, with every operand taken as unsigned.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: `grp_prop` is 1 exactly when `op_a ^ op_b` is all ones (16'hFFFF), and 0 otherwise.
- R4: `grp_gen` is 1 exactly when `op_a + op_b`, without the carry-in, exceeds 16'hFFFF.
- R5: `carry_out` equals `grp_gen | (grp_prop & carry_in)` for every input, so a parent lookahead level can rebuild it.
- R6: The carry into bit positions 4, 8 and 12 comes from the second-level lookahead unit. It agrees with the carry-out that the lower slice computes locally, and a carry chain that crosses one or more slice boundaries gives the correct sum.
- R7: The outputs depend only on the present inputs. Zero operands with a zero carry-in give all-zero outputs, and applying the same inputs again later gives the same outputs.
- R8: At every bit position i, the carry into bit i+1 equals `g_i | (p_i & c_i)`, and sum bit i equals `p_i ^ c_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the result |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_gen | output | 1 | Whole-word generate, for a parent lookahead level |
| grp_prop | output | 1 | Whole-word propagate, for a parent lookahead level |

## Verification
The all-zero inputs and an input applied again later separate a purely combinational result from any held state. All-ones plus one, and a 1 entering a word that is all ones, drive a carry across every slice boundary. In these cases the second-level unit must supply each slice carry-in, which separates a correct lookahead tree from one with a broken boundary term. Alternating patterns make the word propagate everywhere, or generate at every other bit. They separate the group generate output from the group propagate output, and carry-chain ends placed at bits 11 and 15 check single boundaries. Random operands with a random carry-in then compare the sum, carry-out and both group outputs against wide integer arithmetic written in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Width of one lookahead group (slice width and the fan-in of every lookahead unit)
  parameter int unsigned LA_W = 4;

  typedef logic [LA_W-1:0] la_vec_t;
  typedef logic [LA_W:0]   la_carry_t;

  // Every carry in flat sum-of-products form. Index 0 is the carry-in and
  // index LA_W is the group carry-out.
  function automatic la_carry_t lookahead_carries(la_vec_t g, la_vec_t p, logic c0);
    la_carry_t c;
    c[0] = c0;
    for (int k = 1; k <= int'(LA_W); k++) begin
      logic acc;
      logic all_p;
      all_p = c0;
      for (int m = 0; m < k; m++) all_p = all_p & p[m];
      acc = all_p;
      for (int j = 0; j < k; j++) begin
        logic term;
        term = g[j];
        for (int m = j + 1; m < k; m++) term = term & p[m];
        acc = acc | term;
      end
      c[k] = acc;
    end
    return c;
  endfunction

  // A carry leaves the group when some bit generates one and every bit above it propagates
  function automatic logic group_generate(la_vec_t g, la_vec_t p);
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < int'(LA_W); j++) begin
      logic term;
      term = g[j];
      for (int m = j + 1; m < int'(LA_W); m++) term = term & p[m];
      acc = acc | term;
    end
    return acc;
  endfunction

  function automatic logic group_propagate(la_vec_t p);
    return &p;
  endfunction

endpackage

// File: rtl/cla_lcu.sv
module cla_lcu
  import cla_pkg::*;
(
  input  la_vec_t   gen_in,
  input  la_vec_t   prop_in,
  input  logic      cin,
  output la_carry_t carries,
  output logic      grp_gen,
  output logic      grp_prop
);

  always_comb begin
    carries  = lookahead_carries(gen_in, prop_in, cin);
    grp_gen  = group_generate(gen_in, prop_in);
    grp_prop = group_propagate(prop_in);
  end

endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
(
  input  la_vec_t a,
  input  la_vec_t b,
  input  logic    cin,
  output la_vec_t sum,
  output la_vec_t bit_gen,
  output la_vec_t bit_prop,
  output la_vec_t bit_carry,
  output logic    local_cout,
  output logic    grp_gen,
  output logic    grp_prop
);

  la_carry_t carries;

  for (genvar i = 0; i < int'(LA_W); i++) begin : g_bit
    assign bit_gen[i]  = a[i] & b[i];
    assign bit_prop[i] = a[i] ^ b[i];
  end

  cla_lcu u_lcu (
    .gen_in  (bit_gen),
    .prop_in (bit_prop),
    .cin     (cin),
    .carries (carries),
    .grp_gen (grp_gen),
    .grp_prop(grp_prop)
  );

  assign bit_carry  = carries[LA_W-1:0];
  assign local_cout = carries[LA_W];

  for (genvar i = 0; i < int'(LA_W); i++) begin : g_sum
    assign sum[i] = bit_prop[i] ^ bit_carry[i];
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int unsigned GROUP_W = cla_pkg::LA_W
) (
  input  logic [GROUP_W*GROUP_W-1:0] op_a,
  input  logic [GROUP_W*GROUP_W-1:0] op_b,
  input  logic                       carry_in,
  output logic [GROUP_W*GROUP_W-1:0] sum,
  output logic                       carry_out,
  output logic                       grp_gen,
  output logic                       grp_prop
);

  localparam int unsigned NUM_SLICES = GROUP_W;
  localparam int unsigned DATA_W     = GROUP_W * NUM_SLICES;

  // Named internal wires for the checker
  logic [DATA_W-1:0]     bit_gen;
  logic [DATA_W-1:0]     bit_prop;
  logic [DATA_W:0]       carry_vec;   // carry into each bit; top entry is carry_out
  logic [NUM_SLICES-1:0] slice_gg;
  logic [NUM_SLICES-1:0] slice_gp;
  logic [NUM_SLICES-1:0] slice_cout;  // carry-out each slice computes locally
  la_carry_t             l2_carries;  // carries from the second-level unit

  cla_lcu u_lcu_l2 (
    .gen_in  (slice_gg),
    .prop_in (slice_gp),
    .cin     (carry_in),
    .carries (l2_carries),
    .grp_gen (grp_gen),
    .grp_prop(grp_prop)
  );

  for (genvar s = 0; s < int'(NUM_SLICES); s++) begin : g_slice
    localparam int unsigned LO = s * GROUP_W;
    cla_slice u_slice (
      .a         (op_a[LO +: GROUP_W]),
      .b         (op_b[LO +: GROUP_W]),
      .cin       (l2_carries[s]),
      .sum       (sum[LO +: GROUP_W]),
      .bit_gen   (bit_gen[LO +: GROUP_W]),
      .bit_prop  (bit_prop[LO +: GROUP_W]),
      .bit_carry (carry_vec[LO +: GROUP_W]),
      .local_cout(slice_cout[s]),
      .grp_gen   (slice_gg[s]),
      .grp_prop  (slice_gp[s])
    );
  end

  assign carry_out        = l2_carries[NUM_SLICES];
  assign carry_vec[DATA_W] = carry_out;

endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NUM_SLICES = 4
) (
  input logic [DATA_W-1:0]     op_a,
  input logic [DATA_W-1:0]     op_b,
  input logic                  carry_in,
  input logic [DATA_W-1:0]     sum,
  input logic                  carry_out,
  input logic                  grp_gen,
  input logic                  grp_prop,
  input logic [DATA_W-1:0]     bit_gen,
  input logic [DATA_W-1:0]     bit_prop,
  input logic [DATA_W:0]       carry_vec,
  input logic [NUM_SLICES-1:0] slice_cout
);

  localparam int unsigned SLICE_W = DATA_W / NUM_SLICES;

  logic [DATA_W:0] wide_sum;
  logic [DATA_W:0] wide_nocin;

  always_comb begin
    wide_sum   = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in};
    wide_nocin = {1'b0, op_a} + {1'b0, op_b};

    assert_sum_R1: assert ({carry_out, sum} == wide_sum)
      else $error("sum/carry_out differ from a+b+cin");
    assert_cout_R2: assert (carry_out == wide_sum[DATA_W])
      else $error("carry_out wrong");
    assert_gp_R3: assert (grp_prop == (&(op_a ^ op_b)))
      else $error("grp_prop wrong");
    assert_gg_R4: assert (grp_gen == wide_nocin[DATA_W])
      else $error("grp_gen wrong");
    assert_cascade_R5: assert (carry_out == (grp_gen | (grp_prop & carry_in)))
      else $error("cascade relation broken");
    assert_cin0_R8: assert (carry_vec[0] == carry_in)
      else $error("bit 0 carry is not carry_in");

    for (int i = 0; i < int'(DATA_W); i++) begin
      assert_recur_R8: assert (carry_vec[i+1] == (bit_gen[i] | (bit_prop[i] & carry_vec[i])))
        else $error("carry recurrence broken at bit %0d", i);
      assert_sumbit_R8: assert (sum[i] == (bit_prop[i] ^ carry_vec[i]))
        else $error("sum bit %0d wrong", i);
    end

    for (int s = 0; s < int'(NUM_SLICES); s++) begin
      assert_boundary_R6: assert (slice_cout[s] == carry_vec[(s+1)*SLICE_W])
        else $error("slice %0d local carry-out disagrees with level-2 carry", s);
    end
  end

endmodule

bind cla_adder16 cla_adder16_chk #(
  .DATA_W    (DATA_W),
  .NUM_SLICES(NUM_SLICES)
) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum       (sum),
  .carry_out (carry_out),
  .grp_gen   (grp_gen),
  .grp_prop  (grp_prop),
  .bit_gen   (bit_gen),
  .bit_prop  (bit_prop),
  .carry_vec (carry_vec),
  .slice_cout(slice_cout)
);

// File: tb/cla_adder16_test.sv
module cla_adder16_test;

  localparam int unsigned W         = 16;
  localparam int unsigned NVEC      = 12;
  localparam int unsigned NRAND     = 400;
  localparam int unsigned WATCHDOG  = 200000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum;
  logic         carry_out;
  logic         grp_gen;
  logic         grp_prop;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  cla_adder16 uut (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum      (sum),
    .carry_out(carry_out),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop)
  );

  // {a, b, cin, sum, cout, gg, gp}
  localparam logic [51:0] VECS [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1},
    {16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'hAAAA, 16'hAAAA, 1'b0, 16'h5554, 1'b1, 1'b1, 1'b0},
    {16'h5555, 16'h5555, 1'b1, 16'hAAAB, 1'b0, 1'b0, 1'b0},
    {16'h0F0F, 16'h00F1, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, 1'b0, 1'b0},
    {16'h0FFF, 16'h0001, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0},
    {16'h7FFF, 16'h0000, 1'b1, 16'h8000, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [W:0] got, input logic [W:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h (a=%h b=%h cin=%b)",
               req, what, got, exp, op_a, op_b, carry_in);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; carry_in = ci;
    @(negedge clk);
  endtask

  // Bench's own model: wide integer arithmetic
  task automatic check_model(input string tag);
    int unsigned full, nocin;
    full  = int'(op_a) + int'(op_b) + int'(carry_in);
    nocin = int'(op_a) + int'(op_b);
    check({"R1 ", tag}, "sum",       {1'b0, sum},       17'(full & 32'hFFFF));
    check({"R2 ", tag}, "carry_out", {16'd0, carry_out}, 17'(full >> 16));
    check({"R3 ", tag}, "grp_prop",  {16'd0, grp_prop},  17'((op_a ^ op_b) == 16'hFFFF));
    check({"R4 ", tag}, "grp_gen",   {16'd0, grp_gen},   17'(nocin > 32'hFFFF));
    check({"R5 ", tag}, "cascade",   {16'd0, carry_out}, {16'd0, grp_gen | (grp_prop & carry_in)});
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] keep_sum;
    logic         keep_cout;

    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R7: zero inputs after reset give zero outputs
    check("R7", "reset sum",  {1'b0, sum},        17'd0);
    check("R7", "reset cout", {16'd0, carry_out}, 17'd0);
    check("R7", "reset gg",   {16'd0, grp_gen},   17'd0);
    check("R7", "reset gp",   {16'd0, grp_prop},  17'd0);

    // Table walk: R1 R2 R3 R4 against hand-computed results
    for (int v = 0; v < int'(NVEC); v++) begin
      logic [51:0] e;
      e = VECS[v];
      apply(e[51:36], e[35:20], e[19]);
      check("R1", "table sum",  {1'b0, sum},        {1'b0, e[18:3]});
      check("R2", "table cout", {16'd0, carry_out}, {16'd0, e[2]});
      check("R4", "table gg",   {16'd0, grp_gen},   {16'd0, e[1]});
      check("R3", "table gp",   {16'd0, grp_prop},  {16'd0, e[0]});
    end

    // R6: carry chains ending at each slice boundary, and one spanning all slices
    apply(16'h000F, 16'h0001, 1'b0);
    check("R6", "cross bit 4",  {1'b0, sum}, 17'h00010);
    apply(16'h00FF, 16'h0000, 1'b1);
    check("R6", "cross bit 8",  {1'b0, sum}, 17'h00100);
    apply(16'h0FFF, 16'h0000, 1'b1);
    check("R6", "cross bit 12", {1'b0, sum}, 17'h01000);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    check("R6", "all slices", {carry_out, sum}, 17'h1FFFF);

    // R8: alternating propagate/generate at every bit
    apply(16'hA5A5, 16'h5A5B, 1'b0);
    check("R8", "bitwise recurrence", {carry_out, sum}, 17'h10000);
    apply(16'h3333, 16'h1111, 1'b1);
    check("R8", "bitwise recurrence", {carry_out, sum}, 17'h04445);

    // R7: same inputs again give the same outputs
    apply(16'hBEEF, 16'h1234, 1'b1);
    keep_sum  = sum;
    keep_cout = carry_out;
    apply(16'h0000, 16'hFFFF, 1'b0);
    apply(16'hBEEF, 16'h1234, 1'b1);
    check("R7", "repeat", {carry_out, sum}, {keep_cout, keep_sum});

    // Random operands against the bench model
    for (int r = 0; r < int'(NRAND); r++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      check_model("random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule